// File: doc/BRIEF.md
# Fractional-Period PWM Generator

This block produces a PWM waveform, or a plain clock when the duty is set to half, whose period is a whole number of prescaled bus clocks plus a fraction in steps of 1/32 of a clock. A 16-bit counter runs from zero up to a programmed period value. A 5-bit first-order accumulator adds the fractional part once per period. Each period in which the accumulator carries out is one prescaled clock longer. The average frequency therefore does not have to divide the bus clock evenly.

Software writes the period, the two edge positions, the fraction, the fraction enable and the power-of-two prescale into shadow registers through a write-enable and address port. A load-okay command arms a transfer into the active set. The transfer happens at the next counter wrap, so a period is never cut short or mixed between old and new settings. A one-clock pulse marks the start of every period.

Top module: `frac_pwm`

## Requirements
- R1: With the fraction disabled, every period lasts P+1 prescaled ticks, where P is the period register at address 0.
- R2: The prescaler emits one tick every 2^N clocks, where N is taken from bits [3:1] of the control register at address 4. A period therefore spans (P+1)*2^N clocks.
- R3: The fraction F occupies bits [15:11] of address 3, and the fraction enable is bit 0 of address 4. With the enable set, each period lasts P+1 or P+2 ticks. Any 32 consecutive periods together last 32*(P+1)+F ticks.
- R4: With the enable clear, every period lasts exactly P+1 ticks, whatever the value of F.
- R5: When the enable is set, F is non-zero and P is 0xFFFF, the period is loaded as 0xFFFE. With F=1 and a zeroed accumulator, the first period then lasts 65535 clocks at N=0.
- R6: Let c be the counter value. pwm_o is high when ON <= c < OFF, where ON is at address 1 and OFF at address 2, and low otherwise.
- R7: When ON equals OFF, pwm_o stays low for the whole period.
- R8: Writes to addresses 0 to 4 change nothing until a load is armed. Writing address 5 with bit 0 set arms a load, and bit 1 set disarms it; disarm wins when both bits are set. An armed load clears itself once it has taken effect.
- R9: An armed load takes effect at the next counter wrap. The period in progress keeps its old length, and the following period uses the new settings.
- R10: start_o is high for one clock at the start of each period, in the clock where the counter is zero.
- R11: During reset, pwm_o and start_o are low. The reset settings are P=9, ON=2, OFF=5, fraction off and N=0. The first start_o appears 10 clocks after reset is released.
- R12: The accumulator is held at zero while the enable is clear. After the enable is set with F=16, period lengths alternate P+1, P+2, P+1, P+2, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| pwm_o | output | 1 | PWM output |
| start_o | output | 1 | One-clock period-start pulse |

## Verification
A write lands on the first rising edge after it is driven. An armed load waits for the wrap edge. start_o is registered, so it rises in the same clock in which the counter reads zero. pwm_o is decoded from the counter and the active edge registers, so it follows the count within the same clock. The bench samples on the falling edge and takes each start_o pulse as clock zero of a period. From there it counts clocks to the next pulse, and it predicts pwm_o for each clock from the clock index shifted right by N. Register writes are forked inside a running period, so the old-length period and the first new-length period are both measured at known boundaries.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;
  typedef enum logic [2:0] {
    A_PERIOD = 3'd0,
    A_RISE   = 3'd1,
    A_FALL   = 3'd2,
    A_FRAC   = 3'd3,
    A_CTRL   = 3'd4,
    A_LOAD   = 3'd5
  } reg_addr_e;

  localparam int CTRL_EN_BIT = 0;
  localparam int LD_SET_BIT  = 0;
  localparam int LD_CLR_BIT  = 1;
endpackage

// File: rtl/frac_pwm_regs.sv
module frac_pwm_regs
  import frac_pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FRAC_W     = 5,
  parameter int PRE_W      = 3,
  parameter int ADDR_W     = 3,
  parameter int RST_PERIOD = 9,
  parameter int RST_ON     = 2,
  parameter int RST_OFF    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              load_i,
  output logic              ldok_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  on_o,
  output logic [CNT_W-1:0]  off_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              frac_en_o,
  output logic [PRE_W-1:0]  presc_o
);
  localparam logic [CNT_W-1:0] PER_CAP = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0]  sh_per, sh_on, sh_off, per_ld;
  logic [FRAC_W-1:0] sh_frac;
  logic              sh_en;
  logic [PRE_W-1:0]  sh_presc;
  logic sel_per, sel_on, sel_off, sel_frac, sel_ctrl, sel_load;
  logic ld_set, ld_clr;

  assign sel_per  = wr_en_i && (addr_i == ADDR_W'(A_PERIOD));
  assign sel_on   = wr_en_i && (addr_i == ADDR_W'(A_RISE));
  assign sel_off  = wr_en_i && (addr_i == ADDR_W'(A_FALL));
  assign sel_frac = wr_en_i && (addr_i == ADDR_W'(A_FRAC));
  assign sel_ctrl = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
  assign sel_load = wr_en_i && (addr_i == ADDR_W'(A_LOAD));
  assign ld_set   = sel_load && wdata_i[LD_SET_BIT];
  assign ld_clr   = sel_load && wdata_i[LD_CLR_BIT];

  // keep one spare count for the stretched period
  assign per_ld = (sh_en && (sh_frac != '0) && (&sh_per)) ? PER_CAP : sh_per;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_per   <= CNT_W'(RST_PERIOD);
      sh_on    <= CNT_W'(RST_ON);
      sh_off   <= CNT_W'(RST_OFF);
      sh_frac  <= '0;
      sh_en    <= 1'b0;
      sh_presc <= '0;
    end else begin
      if (sel_per)  sh_per  <= wdata_i;
      if (sel_on)   sh_on   <= wdata_i;
      if (sel_off)  sh_off  <= wdata_i;
      if (sel_frac) sh_frac <= wdata_i[CNT_W-1 -: FRAC_W];
      if (sel_ctrl) begin
        sh_en    <= wdata_i[CTRL_EN_BIT];
        sh_presc <= wdata_i[PRE_W:1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o     <= CNT_W'(RST_PERIOD);
      on_o      <= CNT_W'(RST_ON);
      off_o     <= CNT_W'(RST_OFF);
      frac_o    <= '0;
      frac_en_o <= 1'b0;
      presc_o   <= '0;
    end else if (load_i) begin
      per_o     <= per_ld;
      on_o      <= sh_on;
      off_o     <= sh_off;
      frac_o    <= sh_frac;
      frac_en_o <= sh_en;
      presc_o   <= sh_presc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ldok_o <= 1'b0;
    else if (ld_clr)  ldok_o <= 1'b0;
    else if (ld_set)  ldok_o <= 1'b1;
    else if (load_i)  ldok_o <= 1'b0;
  end

  p_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_en_o && (frac_o != '0)) |-> !(&per_o));

  p_ldok_self_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !sel_load) |=> !ldok_o);

  p_active_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(per_o) && $stable(frac_o) && $stable(on_o) && $stable(off_o)));
endmodule

// File: rtl/frac_pwm_presc.sv
module frac_pwm_presc #(
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] presc_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] pcnt, mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(presc_i));
  end

  assign tick_o = &(pcnt | ~mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt <= '0;
    else if (restart_i) pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (presc_i != '0) && !restart_i) |=> !tick_o);
endmodule

// File: rtl/frac_pwm_cnt.sv
module frac_pwm_cnt #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  per_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              frac_en_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o,
  output logic              start_o
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic              stretch;
  logic [CNT_W-1:0]  end_val;

  assign sum     = {1'b0, acc} + {1'b0, frac_i};
  assign stretch = frac_en_i && sum[FRAC_W];
  assign end_val = per_i + CNT_W'(stretch);
  assign wrap_o  = tick_i && (cnt_o == end_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         acc <= '0;
    else if (!frac_en_i) acc <= '0;
    else if (wrap_o)     acc <= sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_o <= 1'b0;
    else         start_o <= wrap_o;
  end

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_o} <= ({1'b0, per_i} + (CNT_W+1)'(1))));

  p_start_at_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (cnt_o == '0));

  p_acc_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frac_en_i |=> (acc == '0));
endmodule

// File: rtl/frac_pwm.sv
module frac_pwm #(
  parameter int CNT_W      = 16,
  parameter int FRAC_W     = 5,
  parameter int PRE_W      = 3,
  parameter int ADDR_W     = 3,
  parameter int RST_PERIOD = 9,
  parameter int RST_ON     = 2,
  parameter int RST_OFF    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic              pwm_o,
  output logic              start_o
);
  logic [CNT_W-1:0]  per, on_v, off_v, cnt;
  logic [FRAC_W-1:0] frac;
  logic              frac_en, ldok, tick, wrap, load;
  logic [PRE_W-1:0]  presc;

  assign load = wrap && ldok;

  frac_pwm_regs #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W),
    .RST_PERIOD(RST_PERIOD), .RST_ON(RST_ON), .RST_OFF(RST_OFF)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .load_i(load), .ldok_o(ldok), .per_o(per), .on_o(on_v), .off_o(off_v),
    .frac_o(frac), .frac_en_o(frac_en), .presc_o(presc)
  );

  frac_pwm_presc #(.PRE_W(PRE_W)) i_presc (
    .clk_i, .rst_ni, .presc_i(presc), .restart_i(load), .tick_o(tick)
  );

  frac_pwm_cnt #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .per_i(per), .frac_i(frac),
    .frac_en_i(frac_en), .cnt_o(cnt), .wrap_o(wrap), .start_o(start_o)
  );

  assign pwm_o = (cnt >= on_v) && (cnt < off_v);

  p_equal_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_v == off_v) |-> !pwm_o);

  p_low_at_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && (on_v != '0)) |-> !pwm_o);
endmodule

// File: tb/test_frac_pwm.sv
module test_frac_pwm;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [2:0]  addr_i;
  logic [15:0] wdata_i;
  logic        pwm_o, start_o;

  int nchk = 0, nfail = 0;
  int cur_on = 2, cur_off = 5, cur_n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frac_pwm i_frac_pwm (
    .clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .pwm_o, .start_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr_i  = 3'(a);
    wdata_i = 16'(d);
    wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // entered on a negedge where start_o is high; leaves on the next such negedge
  task automatic run_period(output int len, output int bad, output int hi);
    int p_on = cur_on;
    int p_off = cur_off;
    int p_n = cur_n;
    int k = 0;
    bad = 0;
    hi = 0;
    do begin
      int c;
      bit e;
      c = k >> p_n;
      e = (c >= p_on) && (c < p_off);
      if (pwm_o !== e) bad++;
      if (pwm_o) hi++;
      k++;
      @(negedge clk);
    end while (!start_o);
    len = k;
  endtask

  task automatic measure(input int nper, output int total, output int bad,
                         output int minl, output int maxl);
    int l, b, h;
    total = 0; bad = 0; minl = 32'h7fffffff; maxl = 0;
    for (int i = 0; i < nper; i++) begin
      run_period(l, b, h);
      total += l;
      bad += b;
      if (l < minl) minl = l;
      if (l > maxl) maxl = l;
    end
  endtask

  task automatic cfg(input int p, input int on, input int off, input int f,
                     input int en, input int n, output int olen, output int obad);
    int h;
    fork
      run_period(olen, obad, h);
      begin
        wr(0, p); wr(1, on); wr(2, off); wr(3, f << 11);
        wr(4, (n << 1) | en); wr(5, 1);
      end
    join
    cur_on = on; cur_off = off; cur_n = n;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int l, b, h, tot, mn, mx, k;
    int pp, pn, pf, pen, non, noff, base, step;
    void'($urandom(32'd7));
    rst_ni = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    chk(pwm_o === 1'b0 && start_o === 1'b0, "R11 reset outputs", int'(pwm_o), 0);
    rst_ni = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!start_o);
    chk(k == 10, "R11 first start after reset", k, 10);

    run_period(l, b, h);
    chk(l == 10, "R1 default period", l, 10);
    chk(b == 0, "R6 default waveform", b, 0);
    chk(h == 3, "R6 default high clocks", h, 3);
    chk(start_o === 1'b1, "R10 start pulse at boundary", int'(start_o), 1);
    @(negedge clk);
    chk(start_o === 1'b0, "R10 pulse one clock", int'(start_o), 0);
    do @(negedge clk); while (!start_o);

    // R8: shadow write without load
    fork run_period(l, b, h); wr(0, 20); join
    measure(3, tot, b, mn, mx);
    chk(tot == 30, "R8 shadow write not applied", tot, 30);
    fork run_period(l, b, h); begin wr(5, 1); wr(5, 2); end join
    chk(l == 10, "R8 period during arm/disarm", l, 10);
    measure(3, tot, b, mn, mx);
    chk(tot == 30, "R8 disarmed load not applied", tot, 30);
    fork run_period(l, b, h); wr(5, 1); join
    chk(l == 10, "R9 old period finishes", l, 10);
    run_period(l, b, h);
    chk(l == 21, "R9 new period after load", l, 21);
    chk(b == 0, "R6 waveform after load", b, 0);
    measure(2, tot, b, mn, mx);
    chk(tot == 42, "R8 load self-clears, setting kept", tot, 42);

    // R4: fraction disabled
    cfg(10, 0, 4, 16, 0, 0, l, b);
    chk(l == 21, "R9 old length kept", l, 21);
    measure(4, tot, b, mn, mx);
    chk(mn == 11 && mx == 11, "R4 no stretch when disabled", mx, 11);

    // R12: accumulator starts from zero
    cfg(10, 0, 4, 16, 1, 0, l, b);
    for (int i = 0; i < 4; i++) begin
      run_period(l, b, h);
      chk(l == ((i % 2) ? 12 : 11), "R12 alternating lengths", l, (i % 2) ? 12 : 11);
    end

    // R7: equal edges
    cfg(12, 5, 5, 0, 0, 1, l, b);
    measure(2, tot, b, mn, mx);
    run_period(l, b, h);
    chk(h == 0, "R7 equal edges low", h, 0);
    chk(tot == 52, "R2 divide by 2", tot, 52);

    // R2: largest prescale
    cfg(3, 1, 3, 0, 0, 7, l, b);
    run_period(l, b, h);
    chk(l == 512, "R2 divide by 128", l, 512);
    chk(h == 256 && b == 0, "R6 prescaled waveform", h, 256);

    // random configurations
    pp = 3; pn = 7; pf = 0; pen = 0;
    for (int r = 0; r < 10; r++) begin
      int np, nn, nf, ne;
      np = 10 + int'($urandom % 31);
      nn = int'($urandom % 3);
      nf = int'($urandom % 32);
      ne = int'($urandom % 2);
      if (r == 0) begin nf = 31; ne = 1; end
      if (r == 1) begin nf = 0; ne = 1; end
      non = int'($urandom % (np + 3));
      noff = int'($urandom % (np + 3));
      cfg(np, non, noff, nf, ne, nn, l, b);
      base = (pp + 1) << pn;
      step = 1 << pn;
      chk(l == base || (l == base + step && pen == 1 && pf != 0), "R9 old period length", l, base);
      chk(b == 0, "R6 waveform old config", b, 0);
      measure(32, tot, b, mn, mx);
      base = (np + 1) << nn;
      step = 1 << nn;
      chk(tot == 32 * base + (ne ? nf * step : 0), "R3 total over 32 periods",
          tot, 32 * base + (ne ? nf * step : 0));
      chk(mn >= base && mx <= base + (ne ? step : 0), "R3 per-period bounds", mx, base);
      chk(b == 0, "R6 random waveform", b, 0);
      pp = np; pn = nn; pf = nf; pen = ne;
    end

    // R5: clamp
    cfg(10, 0, 2, 0, 0, 0, l, b);
    cfg(65535, 0, 2, 1, 1, 0, l, b);
    chk(l == 11, "R9 period before clamp load", l, 11);
    run_period(l, b, h);
    chk(l == 65535, "R5 clamped period", l, 65535);
    chk(b == 0 && h == 2, "R6 waveform in clamped period", h, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule